// File: doc/BRIEF.md
# Averaging ADC conversion sequencer

This block is the digital sequencer for a converter front end with four logical slots, A to D. Each slot has its own configuration. The configuration says whether the slot runs, whether it stops after one result, whether it averages, how many samples it averages, and which of sixteen physical inputs it samples. A cadence counter turns the input clock into sample ticks. On each tick the sequencer may hand one conversion to the analog core through a request/acknowledge pair that carries 12-bit data.

A slot with averaging on collects 4, 8, 16 or 32 samples. It then delivers their mean. A slot with averaging off delivers every sample as it arrives. Each delivered result raises a one-cycle done pulse for its slot on a shared 12-bit result bus. A conversion that the analog core leaves unanswered for too many sample periods is dropped, and the slot raises a timeout pulse.

Software writes one slot at a time. Each write carries a control word and a depth word. The timing word is a plain input, and it may change only while every slot is idle.

Top module: `avg_adc_seq`

## Requirements
- R1: The time between sample ticks is D × (T + 1) × 6 clocks. T is timer_word[TU_W-1:0]. D is the divider chosen by timer_word[31:29]: 0→4, 1→8, 2→16, 3→32, 4→64, and 5, 6 or 7→128. The counting restarts from zero whenever no slot is enabled. A request rises one clock after a tick on which it is issued.
- R2: The control word decodes as follows: bit 31 enables the slot, bit 30 selects one-shot, bit 29 enables averaging, and bits [27:24] are the physical input. While a request is pending, conv_chan carries the physical input of the slot being served.
- R3: With averaging on, depth-word bits [13:12] set the sample count: 0→4, 1→8, 2→16, 3→32. The result is the sum of that many acknowledged samples shifted right by 2, 3, 4 or 5. The sum never overflows, so 32 samples of 0xFFF give 0xFFF.
- R4: With averaging off, each acknowledged sample appears unchanged on res_data, with its slot's done pulse.
- R5: A one-shot slot clears its own enable in the same clock as it delivers its single result.
- R6: A slot that is not one-shot keeps converting and delivers result after result. res_valid never has more than one bit set.
- R7: Enabled slots are served one request at a time, in round-robin order A, B, C, D, starting after the slot served last. A is first after reset.
- R8: If to_limit is not zero and a request receives no acknowledge by the to_limit-th tick after it was issued, the request drops and timeout_pulse pulses for that slot. If to_limit is zero, no timeout occurs.
- R9: Writing a slot's configuration cancels any pending request of that slot. A slot written with bit 31 clear issues no further requests.
- R10: After reset, all slots are disabled, and conv_req, res_valid and timeout_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_word | input | 32 | Divider code [31:29], time unit [TU_W-1:0] |
| to_limit | input | TO_W | Timeout in sample ticks; zero disables it |
| cfg_wr | input | 1 | Write strobe for one slot's configuration |
| cfg_slot | input | 2 | Slot written: 0=A, 1=B, 2=C, 3=D |
| cfg_word1 | input | 32 | Control word (enable, one-shot, average, input select) |
| cfg_word2 | input | 32 | Depth word, sample count code at [13:12] |
| conv_req | output | 1 | Conversion request to the analog core |
| conv_chan | output | 4 | Physical input for the pending request |
| conv_ack | input | 1 | Analog core acknowledge, data valid |
| conv_data | input | 12 | Converted sample |
| slot_en | output | 4 | Current enable bit of each slot |
| res_valid | output | 4 | One-cycle done pulse, one bit per slot |
| res_data | output | 12 | Result that goes with res_valid |
| timeout_pulse | output | 4 | One-cycle timeout pulse, one bit per slot |

## Verification
The assertions assume that the analog core acknowledges only while conv_req is high and for at most one cycle per request. They also assume that the time unit is at least zero, so a tick can never follow another tick directly. The stub in the bench acks a fixed number of cycles after it sees a request, and then deasserts for one cycle. The bench changes timer_word only after it has written every slot disabled. It changes slot configuration one write per cycle, never overlapping an acknowledge on purpose. Cancellation through a write is exercised only while the stub is silent.

// File: rtl/avgseq_pkg.sv
package avgseq_pkg;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int DATA_W = 12;
    localparam int SEL_W  = 4;
    localparam int MAXSH  = 5;
    localparam int ACC_W  = DATA_W + MAXSH;
    localparam int CNT_W  = MAXSH + 1;

    // divider factor for the 3-bit code; codes above 5 saturate at 128
    function automatic logic [7:0] pre_div(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd4;
            3'd1:    return 8'd8;
            3'd2:    return 8'd16;
            3'd3:    return 8'd32;
            3'd4:    return 8'd64;
            default: return 8'd128;
        endcase
    endfunction

    // next enabled slot strictly after the one served last
    function automatic logic [SLOT_W-1:0] rr_pick(input logic [NSLOT-1:0] en,
                                                  input logic [SLOT_W-1:0] last);
        logic [SLOT_W-1:0] pick;
        logic              found;
        pick  = last;
        found = 1'b0;
        for (int i = 1; i <= NSLOT; i++) begin
            logic [SLOT_W-1:0] idx;
            idx = SLOT_W'((int'(last) + i) % NSLOT);
            if (!found && en[idx]) begin
                pick  = idx;
                found = 1'b1;
            end
        end
        return pick;
    endfunction
endpackage

// File: rtl/avgseq_tick.sv
module avgseq_tick
    import avgseq_pkg::*;
#(
    parameter int TU_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [2:0]      pre_code,
    input  logic [TU_W-1:0] tu,
    output logic            tick
);
    localparam int CORE_W = TU_W + 3;

    typedef struct packed {
        logic [6:0]        pc;
        logic [CORE_W-1:0] cc;
    } cad_t;

    cad_t              cad_d, cad_q;
    logic [7:0]        div;
    logic [CORE_W-1:0] core_len;
    logic              pc_wrap, cc_wrap;

    always_comb begin
        div      = pre_div(pre_code);
        core_len = (CORE_W'(tu) + CORE_W'(1)) * CORE_W'(6);
        pc_wrap  = ({1'b0, cad_q.pc} == div - 8'd1);
        cc_wrap  = (cad_q.cc == core_len - CORE_W'(1));
        tick     = run && pc_wrap && cc_wrap;
        cad_d    = cad_q;
        if (!run) begin
            cad_d.pc = '0;
            cad_d.cc = '0;
        end else if (pc_wrap) begin
            cad_d.pc = '0;
            cad_d.cc = cc_wrap ? '0 : cad_q.cc + CORE_W'(1);
        end else begin
            cad_d.pc = cad_q.pc + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cad_q <= '0;
        else        cad_q <= cad_d;
    end

    // R1: a period is at least 24 clocks, so ticks never come back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/avgseq_slot.sv
module avgseq_slot
    import avgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [31:0]       word1,
    input  logic [31:0]       word2,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    output logic              en,
    output logic [SEL_W-1:0]  sel,
    output logic              done,
    output logic [DATA_W-1:0] res
);
    typedef struct packed {
        logic              en;
        logic              single;
        logic              avg;
        logic [SEL_W-1:0]  sel;
        logic [1:0]        depth;
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [DATA_W-1:0] res;
    } slot_t;

    slot_t            s_d, s_q;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] nsamp;
    logic [2:0]       shift;
    logic             unused_cfg;

    assign unused_cfg = ^{word1[28], word1[23:0], word2[31:14], word2[11:0]};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        sum      = s_q.acc + ACC_W'(data);
        nsamp    = CNT_W'(4) << s_q.depth;
        shift    = {1'b0, s_q.depth} + 3'd2;
        if (wr) begin
            s_d.en     = word1[31];
            s_d.single = word1[30];
            s_d.avg    = word1[29];
            s_d.sel    = word1[27:24];
            s_d.depth  = word2[13:12];
            s_d.acc    = '0;
            s_d.cnt    = '0;
        end else if (hit) begin
            if (!s_q.avg) begin
                s_d.res  = data;
                s_d.done = 1'b1;
            end else if (s_q.cnt + CNT_W'(1) == nsamp) begin
                s_d.res  = DATA_W'(sum >> shift);
                s_d.done = 1'b1;
                s_d.acc  = '0;
                s_d.cnt  = '0;
            end else begin
                s_d.acc = sum;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            if (s_d.done && s_q.single) s_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en   = s_q.en;
    assign sel  = s_q.sel;
    assign done = s_q.done;
    assign res  = s_q.res;

    // R3: the sample counter stays below the programmed depth
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < nsamp);
    // R9: the controller only delivers samples to a running slot
    p_hit_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> s_q.en);
endmodule

// File: rtl/avg_adc_seq.sv
module avg_adc_seq
    import avgseq_pkg::*;
#(
    parameter int TU_W = 8,
    parameter int TO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       timer_word,
    input  logic [TO_W-1:0]   to_limit,
    input  logic              cfg_wr,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [31:0]       cfg_word1,
    input  logic [31:0]       cfg_word2,
    output logic              conv_req,
    output logic [SEL_W-1:0]  conv_chan,
    input  logic              conv_ack,
    input  logic [DATA_W-1:0] conv_data,
    output logic [NSLOT-1:0]  slot_en,
    output logic [NSLOT-1:0]  res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [NSLOT-1:0]  timeout_pulse
);
    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] cur;
        logic [TO_W-1:0]   wt;
        logic [NSLOT-1:0]  to;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [NSLOT-1:0]  en_v, done_v;
    logic [SEL_W-1:0]  sel_v [NSLOT];
    logic [DATA_W-1:0] res_v [NSLOT];
    logic              tick, cancel, hit;
    logic              unused_timer;

    assign unused_timer = ^timer_word[28:TU_W];

    avgseq_tick #(.TU_W(TU_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (|en_v),
        .pre_code (timer_word[31:29]),
        .tu       (timer_word[TU_W-1:0]),
        .tick     (tick)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        avgseq_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (cfg_wr && cfg_slot == SLOT_W'(g)),
            .word1 (cfg_word1),
            .word2 (cfg_word2),
            .hit   (hit && ctl_q.cur == SLOT_W'(g)),
            .data  (conv_data),
            .en    (en_v[g]),
            .sel   (sel_v[g]),
            .done  (done_v[g]),
            .res   (res_v[g])
        );
    end

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.to = '0;
        cancel   = ctl_q.busy && cfg_wr && (cfg_slot == ctl_q.cur);
        hit      = ctl_q.busy && conv_ack && !cancel;
        if (ctl_q.busy) begin
            if (cancel || conv_ack) begin
                ctl_d.busy = 1'b0;
            end else if (tick && to_limit != '0) begin
                if (ctl_q.wt + TO_W'(1) == to_limit) begin
                    ctl_d.busy          = 1'b0;
                    ctl_d.to[ctl_q.cur] = 1'b1;
                end else begin
                    ctl_d.wt = ctl_q.wt + TO_W'(1);
                end
            end
        end else if (tick && (|en_v) && !cfg_wr) begin
            ctl_d.busy = 1'b1;
            ctl_d.cur  = rr_pick(en_v, ctl_q.cur);
            ctl_d.wt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.cur <= SLOT_W'(NSLOT - 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        res_data = '0;
        for (int i = 0; i < NSLOT; i++)
            if (done_v[i]) res_data = res_data | res_v[i];
    end

    assign conv_req      = ctl_q.busy;
    assign conv_chan     = sel_v[ctl_q.cur];
    assign slot_en       = en_v;
    assign res_valid     = done_v;
    assign timeout_pulse = ctl_q.to;

    // R2: the input select stays put while a request waits
    p_chan_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_ack && !cfg_wr |=> !conv_req || $stable(conv_chan));
    // R6: at most one slot delivers per cycle
    p_res_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_valid));
    // R8: timeouts are single-slot and only follow a pending request
    p_to_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(timeout_pulse));
    p_to_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|timeout_pulse) |-> $past(conv_req));
    // R9: no request is outstanding for a slot that is switched off
    p_req_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> slot_en[ctl_q.cur]);
endmodule

// File: tb/avg_adc_seq_test.sv
module avg_adc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timer_word = '0;
    logic [7:0]  to_limit = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [31:0] cfg_word1 = '0, cfg_word2 = '0;
    logic        conv_req;
    logic [3:0]  conv_chan;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  slot_en, res_valid, timeout_pulse;
    logic [11:0] res_data;

    always #2 clk = ~clk;

    avg_adc_seq uut (
        .clk(clk), .rst_n(rst_n), .timer_word(timer_word), .to_limit(to_limit),
        .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_data(conv_data),
        .slot_en(slot_en), .res_valid(res_valid), .res_data(res_data), .timeout_pulse(timeout_pulse)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model state
    bit m_en[4], m_sgl[4], m_avg[4];
    int m_sel[4], m_dep[4], m_acc[4], m_cnt[4];
    int m_phase, m_cur, m_wt, m_res;
    bit m_busy;
    bit [3:0] m_done, m_to;

    // stub and trackers
    bit stub_on = 1'b1, stub_const = 1'b0;
    int stub_cval = 0, stub_w = 0, stub_n = 0;
    int cyc = 0, rise_cnt = 0, last_rise = 0, rise_gap = 0, to_cnt = 0;
    int last_res[4], res_cnt[4];
    bit [15:0] rr_hist = '0;
    bit prev_req = 1'b0;

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            m_en[s] = 0; m_sgl[s] = 0; m_avg[s] = 0;
            m_sel[s] = 0; m_dep[s] = 0; m_acc[s] = 0; m_cnt[s] = 0;
        end
        m_phase = 0; m_cur = 3; m_wt = 0; m_res = 0; m_busy = 0;
        m_done = '0; m_to = '0;
    endtask

    task automatic model_step();
        bit run, tick, cancel, hit;
        int div, period, code, old_cur;
        run = m_en[0] | m_en[1] | m_en[2] | m_en[3];
        code = int'(timer_word[31:29]);
        div = (code >= 5) ? 128 : (4 << code);
        period = div * (int'(timer_word[7:0]) + 1) * 6;
        tick = run && (m_phase == period - 1);
        m_phase = run ? (m_phase + 1) % period : 0;
        old_cur = m_cur;
        cancel = m_busy && cfg_wr && (int'(cfg_slot) == m_cur);
        hit = m_busy && conv_ack && !cancel;
        m_to = '0;
        m_done = '0;
        if (m_busy) begin
            if (cancel || conv_ack) m_busy = 0;
            else if (tick && to_limit != 0) begin
                if (m_wt + 1 == int'(to_limit)) begin m_busy = 0; m_to[m_cur] = 1; end
                else m_wt++;
            end
        end else if (tick && run && !cfg_wr) begin
            for (int i = 1; i <= 4; i++)
                if (!m_busy && m_en[(m_cur + i) % 4]) begin
                    m_busy = 1; m_cur = (m_cur + i) % 4;
                end
            m_wt = 0;
        end
        for (int s = 0; s < 4; s++) begin
            if (cfg_wr && int'(cfg_slot) == s) begin
                m_en[s] = cfg_word1[31]; m_sgl[s] = cfg_word1[30]; m_avg[s] = cfg_word1[29];
                m_sel[s] = int'(cfg_word1[27:24]); m_dep[s] = int'(cfg_word2[13:12]);
                m_acc[s] = 0; m_cnt[s] = 0;
            end else if (hit && s == old_cur) begin
                if (!m_avg[s]) begin m_res = int'(conv_data); m_done[s] = 1; end
                else begin
                    m_acc[s] += int'(conv_data);
                    m_cnt[s]++;
                    if (m_cnt[s] == (4 << m_dep[s])) begin
                        m_res = m_acc[s] / (4 << m_dep[s]);
                        m_done[s] = 1; m_acc[s] = 0; m_cnt[s] = 0;
                    end
                end
                if (m_done[s] && m_sgl[s]) m_en[s] = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) model_reset();
        else begin
            check("R1 conv_req", int'(conv_req), int'(m_busy));
            if (m_busy) check("R7 conv_chan", int'(conv_chan), m_sel[m_cur]);
            check("R6 res_valid", int'(res_valid), int'(m_done));
            if (m_done != 0) check("R3 res_data", int'(res_data), m_res);
            check("R8 timeout_pulse", int'(timeout_pulse), int'(m_to));
            check("R5 slot_en", int'({m_en[3], m_en[2], m_en[1], m_en[0]}), int'(slot_en));
            // trackers
            cyc++;
            if (conv_req && !prev_req) begin
                rise_cnt++; rise_gap = cyc - last_rise; last_rise = cyc;
                rr_hist = {rr_hist[11:0], conv_chan};
            end
            prev_req = conv_req;
            if (timeout_pulse != 0) to_cnt++;
            for (int s = 0; s < 4; s++)
                if (res_valid[s]) begin last_res[s] = int'(res_data); res_cnt[s]++; end
            // analog stub
            if (stub_on && conv_req && !conv_ack) begin
                if (stub_w == 1) begin
                    conv_ack = 1'b1;
                    conv_data = stub_const ? 12'(stub_cval) : 12'((stub_n * 37 + 11) & 12'hFFF);
                    stub_n++; stub_w = 0;
                end else stub_w++;
            end else begin
                conv_ack = 1'b0;
                if (!conv_req) stub_w = 0;
            end
            model_step();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_slot(input int s, input logic [31:0] w1, input logic [31:0] w2);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_slot = 2'(s); cfg_word1 = w1; cfg_word2 = w2;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic all_off();
        for (int s = 0; s < 4; s++) write_slot(s, 32'h0, 32'h0);
        wait_cyc(4);
    endtask

    localparam logic [31:0] EN = 32'h8000_0000, SGL = 32'h4000_0000, AVG = 32'h2000_0000;

    int snap;

    initial begin
        for (int s = 0; s < 4; s++) begin last_res[s] = 0; res_cnt[s] = 0; end
        wait_cyc(3);
        check("R10 slot_en after reset", int'(slot_en), 0);
        check("R10 conv_req after reset", int'(conv_req), 0);
        check("R10 res_valid after reset", int'(res_valid), 0);
        check("R10 timeout after reset", int'(timeout_pulse), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // round robin with mixed modes, period 24
        write_slot(0, EN | AVG | (32'd1 << 24), 32'h0);
        write_slot(1, EN | SGL | (32'd2 << 24), 32'h0);
        write_slot(2, EN | AVG | (32'd3 << 24), 32'h3000);
        write_slot(3, EN | (32'd4 << 24), 32'h0);
        wait_cyc(100);
        check("R7 round-robin order", int'(rr_hist), 16'h1234);
        check("R2 select of slot A", int'(rr_hist[15:12]), 1);
        wait_cyc(2000);
        check("R5 one-shot slot B cleared", int'(slot_en[1]), 0);
        check("R4 one-shot slot B delivered once", res_cnt[1], 1);
        check("R6 continuous slot D repeats", int'(res_cnt[3] >= 2), 1);

        // full-scale average over 32 samples
        all_off();
        stub_const = 1'b1; stub_cval = 12'hFFF;
        write_slot(0, EN | AVG | (32'd7 << 24), 32'h3000);
        wait_cyc(32 * 24 + 100);
        check("R3 32-sample mean of 0xFFF", last_res[0], 12'hFFF);
        stub_cval = 12'h123;
        write_slot(1, EN | SGL | (32'd9 << 24), 32'h0);
        wait_cyc(120);
        check("R4 raw sample passes unchanged", last_res[1], 12'h123);

        // cadence with saturated divider code 6, time unit 1
        all_off();
        stub_const = 1'b0;
        timer_word = {3'd6, 29'd1};
        write_slot(0, EN | (32'd5 << 24), 32'h0);
        wait_cyc(3 * 1536 + 60);
        check("R1 period code6 tu1", rise_gap, 1536);
        all_off();
        timer_word = {3'd2, 29'd3};
        write_slot(0, EN | (32'd5 << 24), 32'h0);
        wait_cyc(3 * 384 + 60);
        check("R1 period code2 tu3", rise_gap, 384);

        // timeout with a silent core
        all_off();
        timer_word = '0;
        stub_on = 1'b0;
        to_limit = 8'd3;
        write_slot(2, EN | (32'd3 << 24), 32'h0);
        snap = to_cnt;
        wait_cyc(300);
        check("R8 timeouts raised", int'(to_cnt > snap), 1);
        to_limit = 8'd0;
        wait_cyc(100);
        snap = to_cnt;
        wait_cyc(300);
        check("R8 limit zero gives no timeout", to_cnt, snap);

        // cancel a pending request by disabling its slot
        check("R9 request pending before cancel", int'(conv_req), 1);
        write_slot(2, 32'h0, 32'h0);
        wait_cyc(2);
        check("R9 request dropped", int'(conv_req), 0);
        check("R9 slot disabled", int'(slot_en), 0);
        snap = rise_cnt;
        wait_cyc(200);
        check("R9 no further requests", rise_cnt, snap);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule